// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache Lookup

This block is the lookup stage of a direct-mapped data cache that avoids waiting for address translation before touching its arrays. The set index and the word select come only from the low bits of the virtual address, and those bits are never changed by translation. The tag, valid and data arrays can therefore be read in the same cycle in which an eight-entry, fully associative translation buffer converts the virtual page number into a physical page number. One cycle later the stored tag is compared against the physical address, and the block reports a hit, a cache miss or a translation miss.

With the default parameters a line is 64 bytes and there are 512 lines. Index plus block offset span 15 bits, so pages must be at least 32 KB, and the whole cache is no larger than one page. Lines are filled and tagged by physical address. Two virtual pages that map to one physical page therefore always meet in the same line, and a block is never cached twice. An elaboration-time check rejects any parameter set whose index and block offset bits do not fit inside the page offset.

Writes go through to memory on a separate write port and do not allocate a line on a miss. A read miss raises a refill request carrying the physical block address, and the line is installed when the full line of refill data arrives. Callers leave at least one idle cycle between requests, issue no request while a refill is pending, and never load the same virtual page number into two translation slots.

Top module: `vipt_dcache`

## Requirements
- R1: After reset no line is valid and no translation slot is valid. The first request then reports a translation miss, and once a mapping exists the first read of any line reports a cache miss.
- R2: A request presented with req_valid produces exactly one response, with resp_valid high in the following cycle. The line is selected by req_vaddr[14:6], and lines 0 and 511 behave like any other.
- R3: tlb_fill_en writes slot tlb_fill_slot with a valid virtual and physical page number. A request whose req_vaddr[31:15] matches no valid slot reports resp_tlb_miss with no hit, no refill request and no memory write. Refilling a slot replaces its old mapping.
- R4: A response reports resp_hit only when the indexed line is valid and its stored tag equals the translated physical address bits [31:15]. Virtual page bits never take part in the compare: an alias of a cached physical page hits, and a different physical page at the same index misses.
- R5: A read hit returns on resp_rdata the 32-bit word selected by address bits [5:2]. Word k of a line occupies bits 32k+31 down to 32k.
- R6: A read miss raises refill_req from the cycle after the miss response, with refill_addr equal to physical address bits [31:6]. Both hold until refill_valid is seen. The line is then written from refill_data (word k in bits 32k+31:32k), takes the new tag and becomes valid, and refill_req falls in the next cycle.
- R7: Every write that translates asserts mem_wr_valid in its response cycle, with mem_wr_addr equal to the physical byte address (low two bits zero) and mem_wr_data equal to the write data. This happens whether the write hits or misses.
- R8: A write hit replaces the addressed word in the line. A write miss leaves the line untouched and raises no refill request, so a later read of that address still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| tlb_fill_en | input | 1 | Load one translation slot |
| tlb_fill_slot | input | 3 | Slot to load |
| tlb_fill_vpn | input | 17 | Virtual page number for the slot |
| tlb_fill_ppn | input | 17 | Physical page number for the slot |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | Cache hit |
| resp_miss | output | 1 | Translated, but the line does not hold the block |
| resp_tlb_miss | output | 1 | No translation found |
| resp_rdata | output | 32 | Read data on a read hit |
| refill_req | output | 1 | Line refill wanted |
| refill_addr | output | 26 | Physical block address of the refill |
| refill_valid | input | 1 | Refill line present |
| refill_data | input | 512 | Full refill line |
| mem_wr_valid | output | 1 | Write-through store |
| mem_wr_addr | output | 32 | Physical byte address of the store |
| mem_wr_data | output | 32 | Store data |

## Verification
Each response flag, the read data and the write-through store are due in the cycle after the request edge. The bench samples them on the falling edge one half period after that edge. A refill request is due one cycle later than the miss response, so the bench checks it at the next falling edge and drives refill_valid there. It then checks that the request has dropped at the falling edge after the line is written. Requests keep one idle cycle between them, so each check sees only the response to its own request.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [1:0] {
        RK_NONE    = 2'd0,
        RK_HIT     = 2'd1,
        RK_MISS    = 2'd2,
        RK_XLMISS  = 2'd3
    } resp_kind_e;

endpackage

// File: rtl/vipt_xlate.sv
module vipt_xlate #(
    parameter int VPN_W = 17,
    parameter int PPN_W = 17,
    parameter int SLOTS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_en,
    input  logic [$clog2(SLOTS)-1:0] fill_slot,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PPN_W-1:0]         fill_ppn,
    input  logic [VPN_W-1:0]         lk_vpn,
    output logic                     lk_hit,
    output logic [PPN_W-1:0]         lk_ppn
);

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    slot_t            slot_d [SLOTS];
    slot_t            slot_q [SLOTS];
    logic [SLOTS-1:0] match;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (fill_en) begin
            slot_d[fill_slot] = '{vld: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = slot_q[g].vld && (slot_q[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < SLOTS; i++) begin
            lk_ppn = lk_ppn | ({PPN_W{match[i]}} & slot_q[i].ppn);
        end
    end

    assign lk_hit = |match;

    // R3: distinct page numbers per slot give at most one matching slot
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/vipt_arrays.sv
module vipt_arrays #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 17,
    parameter int WSEL_W = 4,
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        rd_valid,
    output logic [TAG_W-1:0]            rd_tag,
    output logic [(WORD_W<<WSEL_W)-1:0] rd_line,
    input  logic                        wr_word_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WSEL_W-1:0]           wr_wsel,
    input  logic [WORD_W-1:0]           wr_word,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [(WORD_W<<WSEL_W)-1:0] fill_line
);

    localparam int LINES  = 1 << IDX_W;
    localparam int LINE_W = WORD_W << WSEL_W;

    logic [LINES-1:0]  vld_d, vld_q;
    logic              rd_valid_d, rd_valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] data_mem [LINES];
    logic [TAG_W-1:0]  rd_tag_q;
    logic [LINE_W-1:0] rd_line_q;

    always_comb begin
        vld_d = vld_q;
        if (fill_en) vld_d[fill_idx] = 1'b1;
        rd_valid_d = rd_en ? vld_q[rd_idx] : rd_valid_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q      <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            vld_q      <= vld_d;
            rd_valid_q <= rd_valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx]  <= fill_tag;
            data_mem[fill_idx] <= fill_line;
        end else if (wr_word_en) begin
            data_mem[wr_idx][wr_wsel*WORD_W +: WORD_W] <= wr_word;
        end
        if (rd_en) begin
            rd_tag_q  <= tag_mem[rd_idx];
            rd_line_q <= data_mem[rd_idx];
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_tag   = rd_tag_q;
    assign rd_line  = rd_line_q;

    // R1: the first cycle out of reset sees every line invalid
    a_r1_lines_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_q == '0));

    // R6: a fill leaves its line valid on the next cycle
    a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_idx)]);

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
    import vipt_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PG_OFF_W = 15,
    parameter int IDX_W    = 9,
    parameter int BLK_W    = 6,
    parameter int WORD_W   = 32,
    parameter int TLB_N    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_we,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [WORD_W-1:0]             req_wdata,
    input  logic                          tlb_fill_en,
    input  logic [$clog2(TLB_N)-1:0]      tlb_fill_slot,
    input  logic [VA_W-PG_OFF_W-1:0]      tlb_fill_vpn,
    input  logic [PA_W-PG_OFF_W-1:0]      tlb_fill_ppn,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic                          resp_miss,
    output logic                          resp_tlb_miss,
    output logic [WORD_W-1:0]             resp_rdata,
    output logic                          refill_req,
    output logic [PA_W-BLK_W-1:0]         refill_addr,
    input  logic                          refill_valid,
    input  logic [(8<<BLK_W)-1:0]         refill_data,
    output logic                          mem_wr_valid,
    output logic [PA_W-1:0]               mem_wr_addr,
    output logic [WORD_W-1:0]             mem_wr_data
);

    localparam int VPN_W  = VA_W - PG_OFF_W;
    localparam int PPN_W  = PA_W - PG_OFF_W;
    localparam int TAG_W  = PA_W - IDX_W - BLK_W;
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = BLK_W - BYTE_W;
    localparam int LINE_W = 8 << BLK_W;
    localparam int BA_W   = PA_W - BLK_W;

    if (IDX_W + BLK_W > PG_OFF_W) begin : g_bad_geometry
        $error("index and block offset must fit inside the page offset");
    end

    typedef struct packed {
        logic              vld;
        logic              we;
        logic              xl_hit;
        logic [PA_W-1:0]   pa;
        logic [WORD_W-1:0] wdata;
        logic              rf_pend;
        logic [BA_W-1:0]   rf_addr;
    } st_t;

    st_t st_d, st_q;

    logic              xl_hit;
    logic [PPN_W-1:0]  xl_ppn;
    logic              arr_valid;
    logic [TAG_W-1:0]  arr_tag;
    logic [LINE_W-1:0] arr_line;
    resp_kind_e        kind;
    logic              tag_ok;
    logic [WSEL_W-1:0] wsel;
    logic              fill_go;

    vipt_xlate #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(TLB_N)) i_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (tlb_fill_en),
        .fill_slot(tlb_fill_slot),
        .fill_vpn (tlb_fill_vpn),
        .fill_ppn (tlb_fill_ppn),
        .lk_vpn   (req_vaddr[VA_W-1:PG_OFF_W]),
        .lk_hit   (xl_hit),
        .lk_ppn   (xl_ppn)
    );

    assign fill_go = st_q.rf_pend && refill_valid;
    assign wsel    = st_q.pa[BLK_W-1:BYTE_W];

    vipt_arrays #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W)) i_arrays (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (req_valid),
        .rd_idx    (req_vaddr[IDX_W+BLK_W-1:BLK_W]),
        .rd_valid  (arr_valid),
        .rd_tag    (arr_tag),
        .rd_line   (arr_line),
        .wr_word_en(kind == RK_HIT && st_q.we),
        .wr_idx    (st_q.pa[IDX_W+BLK_W-1:BLK_W]),
        .wr_wsel   (wsel),
        .wr_word   (st_q.wdata),
        .fill_en   (fill_go),
        .fill_idx  (st_q.rf_addr[IDX_W-1:0]),
        .fill_tag  (st_q.rf_addr[BA_W-1:IDX_W]),
        .fill_line (refill_data)
    );

    always_comb begin
        tag_ok = arr_valid && (arr_tag == st_q.pa[PA_W-1:IDX_W+BLK_W]);
        if (!st_q.vld)         kind = RK_NONE;
        else if (!st_q.xl_hit) kind = RK_XLMISS;
        else if (tag_ok)       kind = RK_HIT;
        else                   kind = RK_MISS;

        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.we     = req_we;
            st_d.xl_hit = xl_hit;
            st_d.pa     = {xl_ppn, req_vaddr[PG_OFF_W-1:0]};
            st_d.wdata  = req_wdata;
        end
        if (fill_go) begin
            st_d.rf_pend = 1'b0;
        end else if (kind == RK_MISS && !st_q.we) begin
            st_d.rf_pend = 1'b1;
            st_d.rf_addr = st_q.pa[PA_W-1:BLK_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid    = st_q.vld;
    assign resp_hit      = (kind == RK_HIT);
    assign resp_miss     = (kind == RK_MISS);
    assign resp_tlb_miss = (kind == RK_XLMISS);
    assign resp_rdata    = arr_line[wsel*WORD_W +: WORD_W];
    assign refill_req    = st_q.rf_pend;
    assign refill_addr   = st_q.rf_addr;
    assign mem_wr_valid  = st_q.vld && st_q.we && st_q.xl_hit;
    assign mem_wr_addr   = {st_q.pa[PA_W-1:BYTE_W], {BYTE_W{1'b0}}};
    assign mem_wr_data   = st_q.wdata;

    // R2: every request is answered on the next cycle
    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R2: no response without a request
    a_r2_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R3: a response carries exactly one outcome flag
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_hit, resp_miss, resp_tlb_miss}) == 1));

    // R6: refill request and address hold until the line arrives
    a_r6_refill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

    // R6: refill request drops after the line is taken
    a_r6_refill_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_valid) |=> !refill_req);

    // R7: stores leave only for translated requests
    a_r7_store_translated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (resp_valid && !resp_tlb_miss));

    // R8: a write miss starts no refill
    a_r8_no_write_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_miss && mem_wr_valid && !refill_req) |=> !refill_req);

endmodule

// File: tb/test_vipt_dcache.sv
module test_vipt_dcache;

    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_we;
    logic [31:0]  req_vaddr, req_wdata;
    logic         tlb_fill_en;
    logic [2:0]   tlb_fill_slot;
    logic [16:0]  tlb_fill_vpn, tlb_fill_ppn;
    logic         resp_valid, resp_hit, resp_miss, resp_tlb_miss;
    logic [31:0]  resp_rdata;
    logic         refill_req;
    logic [25:0]  refill_addr;
    logic         refill_valid;
    logic [511:0] refill_data;
    logic         mem_wr_valid;
    logic [31:0]  mem_wr_addr, mem_wr_data;

    int n_run  = 0;
    int n_fail = 0;

    // bench reference state
    bit          m_tv   [8];
    logic [16:0] m_tvpn [8];
    logic [16:0] m_tppn [8];
    bit          m_cv   [512];
    logic [16:0] m_ctag [512];
    logic [31:0] m_mem  [logic [31:0]];

    logic [16:0] vpn_pool [10];
    logic [8:0]  idx_pool [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_dcache i_vipt_dcache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .tlb_fill_en(tlb_fill_en), .tlb_fill_slot(tlb_fill_slot),
        .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_ppn(tlb_fill_ppn),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_tlb_miss(resp_tlb_miss), .resp_rdata(resp_rdata),
        .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_data(refill_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] pa);
        logic [31:0] a;
        a = {pa[31:2], 2'b00};
        if (m_mem.exists(a)) return m_mem[a];
        return {a[15:0], a[31:16]} ^ 32'h5EED_1234;
    endfunction

    function automatic bit xlate(input logic [16:0] vpn, output logic [16:0] ppn);
        ppn = '0;
        for (int s = 0; s < 8; s++) begin
            if (m_tv[s] && m_tvpn[s] == vpn) begin
                ppn = m_tppn[s];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] mk_va(input logic [16:0] vpn, input logic [8:0] idx,
                                          input logic [3:0] w);
        return {vpn, idx, w, 2'b00};
    endfunction

    task automatic tlb_load(input logic [2:0] s, input logic [16:0] vpn, input logic [16:0] ppn);
        @(negedge clk);
        tlb_fill_en = 1'b1; tlb_fill_slot = s; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn;
        @(negedge clk);
        tlb_fill_en = 1'b0;
        m_tv[s] = 1'b1; m_tvpn[s] = vpn; m_tppn[s] = ppn;
    endtask

    // one request; returns the expected outcome code 0 hit, 1 miss, 2 translation miss
    task automatic access(input bit we, input logic [31:0] va, input logic [31:0] wd,
                          output int outcome);
        logic [16:0]  ppn;
        logic [31:0]  pa;
        logic [8:0]   idx;
        bit           th, hit;
        logic [511:0] line;
        th   = xlate(va[31:15], ppn);
        pa   = {ppn, va[14:0]};
        idx  = va[14:6];
        hit  = th && m_cv[idx] && (m_ctag[idx] == pa[31:15]);
        outcome = !th ? 2 : (hit ? 0 : 1);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_vaddr = va; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 resp_valid", resp_valid, 1);
        chk("R3 resp_tlb_miss", resp_tlb_miss, !th);
        chk("R4 resp_hit", resp_hit, hit);
        chk("R4 resp_miss", resp_miss, th && !hit);
        if (hit && !we) chk("R5 resp_rdata", resp_rdata, mem_rd(pa));
        chk("R7 mem_wr_valid", mem_wr_valid, we && th);
        if (we && th) begin
            chk("R7 mem_wr_addr", mem_wr_addr, {pa[31:2], 2'b00});
            chk("R7 mem_wr_data", mem_wr_data, wd);
            m_mem[{pa[31:2], 2'b00}] = wd;
        end
        @(negedge clk);
        if (th && !hit && !we) begin
            chk("R6 refill_req raised", refill_req, 1);
            chk("R6 refill_addr", refill_addr, pa[31:6]);
            for (int k = 0; k < 16; k++) line[k*32 +: 32] = mem_rd({pa[31:6], k[3:0], 2'b00});
            refill_valid = 1'b1; refill_data = line;
            @(negedge clk);
            refill_valid = 1'b0;
            chk("R6 refill_req dropped", refill_req, 0);
            m_cv[idx] = 1'b1; m_ctag[idx] = pa[31:15];
        end else if (we) begin
            chk("R8 no refill on write", refill_req, 0);
        end else begin
            chk("R3 no refill", refill_req, 0);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int oc;
        int seed;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_vaddr = '0; req_wdata = '0;
        tlb_fill_en = 1'b0; tlb_fill_slot = '0; tlb_fill_vpn = '0; tlb_fill_ppn = '0;
        refill_valid = 1'b0; refill_data = '0;
        for (int i = 0; i < 8; i++) m_tv[i] = 1'b0;
        for (int i = 0; i < 512; i++) m_cv[i] = 1'b0;
        for (int i = 0; i < 10; i++) vpn_pool[i] = 17'h00040 + 17'(i * 7);
        idx_pool[0] = 9'd0; idx_pool[1] = 9'd1; idx_pool[2] = 9'd37; idx_pool[3] = 9'd511;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs after reset
        chk("R1 resp_valid idle", resp_valid, 0);
        chk("R1 refill_req idle", refill_req, 0);
        chk("R1 mem_wr_valid idle", mem_wr_valid, 0);
        // R1: empty translation buffer
        access(0, mk_va(vpn_pool[0], 9'd5, 4'd0), 0, oc);
        chk("R1 empty tlb gives translation miss", oc, 2);

        // slots 0 and 1 alias the same physical page
        tlb_load(0, vpn_pool[0], 17'h00100);
        tlb_load(1, vpn_pool[1], 17'h00100);
        for (int s = 2; s < 8; s++) tlb_load(3'(s), vpn_pool[s], 17'h00100 + 17'(s - 1));

        // R1: lines start invalid
        access(0, mk_va(vpn_pool[0], 9'd5, 4'd3), 0, oc);
        chk("R1 first read misses", oc, 1);
        access(0, mk_va(vpn_pool[0], 9'd5, 4'd3), 0, oc);
        chk("R5 read after refill hits", oc, 0);
        // R4: alias hits the same line
        access(0, mk_va(vpn_pool[1], 9'd5, 4'd15), 0, oc);
        chk("R4 alias hits", oc, 0);
        // R4: different physical page, same index, misses
        access(0, mk_va(vpn_pool[2], 9'd5, 4'd0), 0, oc);
        chk("R4 other page misses", oc, 1);
        // R2: boundary lines
        access(0, mk_va(vpn_pool[3], 9'd511, 4'd15), 0, oc);
        access(0, mk_va(vpn_pool[3], 9'd511, 4'd15), 0, oc);
        chk("R2 last line hits", oc, 0);
        access(0, mk_va(vpn_pool[3], 9'd0, 4'd0), 0, oc);
        chk("R2 line 0 misses", oc, 1);
        // R8: write hit then read back
        access(1, mk_va(vpn_pool[3], 9'd511, 4'd7), 32'hCAFE_0001, oc);
        chk("R8 write hit", oc, 0);
        access(0, mk_va(vpn_pool[3], 9'd511, 4'd7), 0, oc);
        chk("R8 read after write hit", oc, 0);
        // R8: write miss does not allocate
        access(1, mk_va(vpn_pool[4], 9'd200, 4'd2), 32'hBEEF_0002, oc);
        chk("R8 write miss", oc, 1);
        access(0, mk_va(vpn_pool[4], 9'd200, 4'd2), 0, oc);
        chk("R8 read still misses", oc, 1);
        access(0, mk_va(vpn_pool[4], 9'd200, 4'd2), 0, oc);
        chk("R8 refilled line holds store", oc, 0);
        // R3: remap a slot
        tlb_load(7, vpn_pool[8], 17'h00155);
        access(0, mk_va(vpn_pool[7], 9'd1, 4'd0), 0, oc);
        chk("R3 replaced mapping gone", oc, 2);
        access(0, mk_va(vpn_pool[8], 9'd1, 4'd0), 0, oc);
        chk("R3 new mapping translates", oc, 1);

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [16:0] vp;
            logic [8:0]  ix;
            bit          w;
            vp = vpn_pool[$urandom_range(9)];
            ix = idx_pool[$urandom_range(3)];
            w  = ($urandom_range(9) < 3);
            access(w, mk_va(vp, ix, 4'($urandom_range(15))), $urandom, oc);
        end

        finish_run();
    end

endmodule